// File: doc/BRIEF.md
# Tapped Binary Divider with Sectioned Test Mode

This block is a 24-stage divide-by-two chain that counts falling edges of a slow count-clock input. It exposes only the seven most significant stages as taps. A chip uses it to derive very low frequencies, from seconds to minutes, out of a faster reference. The count clock is sampled in a system clock domain. Each detected falling edge advances one synchronous counter, so the block has no real ripple chain and its timing is plain.

An active-high asynchronous clear forces every stage to zero at once and holds the chain there for as long as it is high. A test select is captured only while the clear is high. When it is set, the chain is cut into three 8-stage sections, and all three step on every count edge. After 255 edges every stage reads one, so the full chain can be proven in a few hundred edges rather than sixteen million.

Top module: `tap_divider`

## Requirements
- R1: While `clear` is high, all stages are zero and `taps` reads 0. This takes effect asynchronously, without waiting for a `clk` edge.
- R2: The chain advances only on a high-to-low transition of `cntClk`. A rising transition, or a steady level, leaves `taps` unchanged.
- R3: In normal mode, `taps[k]` equals bit `STAGES-TAPS+k` of the number of falling edges counted since the last clear. With the defaults, `taps[0]` is stage 18 (count bit 17) and `taps[6]` is stage 24 (count bit 23).
- R4: In normal mode the count wraps modulo 2^STAGES: the edge after the all-ones state returns every stage to zero.
- R5: In test mode, each SECTION-stage section counts every falling edge on its own, with no carry between sections. With the defaults, `taps` is 7'h7F after 255 edges.
- R6: In test mode, the edge after the all-ones state returns every stage, and so `taps`, to zero. With the defaults this is the 256th edge.
- R7: `testSel` is ignored while `clear` is low. The mode in force is the value `testSel` held while `clear` was last high.
- R8: Falling edges on `cntClk` that occur while `clear` is high are not counted. Counting resumes from zero after `clear` falls.
- R9: After a falling edge of `cntClk`, `taps` shows the new count within four `clk` cycles. Each edge advances the chain by exactly one count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the count clock |
| clear | input | 1 | Asynchronous active-high master clear |
| cntClk | input | 1 | Count clock; its falling edges are counted |
| testSel | input | 1 | Test-mode select, captured while `clear` is high |
| taps | output | TAPS | Outputs of the top TAPS stages, LSB = lowest tapped stage |

## Verification
The hardest state to reach from the ports is a change in the top taps in normal mode. A change in tap stage 18 needs 2^17 edges, and a wrap needs 2^24. The bench therefore drives a second instance with 12 stages in 4-stage sections from the same inputs. It sweeps that instance through more than a full wrap, edge by edge, and checks every tapped bit against an arithmetic count. The default instance is brought to its all-ones state through test mode, which takes 255 edges. The test select is toggled in the middle of the sweep to show that it is ignored outside clear.

// File: rtl/tap_divider_pkg.sv
package tap_divider_pkg;

  // Strobes from control to the stage chain
  typedef struct packed {
    logic advance;   // one-cycle pulse per detected count-clock falling edge
    logic testMode;  // sections step in parallel when set
  } divStrobe_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import tap_divider_pkg::*;
(
  input  logic       clk,
  input  logic       clear,
  input  logic       cntClk,
  input  logic       testSel,
  output divStrobe_t stb
);

  logic [1:0] syncQ;
  logic       prevQ;
  logic       modeQ;

  // Two-flop synchronizer plus a history flop. Cleared to zero so a high
  // count clock at release never looks like a falling edge.
  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], cntClk};
      prevQ <= syncQ[1];
    end
  end

  // The mode follows testSel only while clear is held, and is frozen after that
  always_ff @(posedge clk or posedge clear) begin
    if (clear) modeQ <= testSel;
    else       modeQ <= modeQ;
  end

  always_comb begin
    stb.advance  = prevQ & ~syncQ[1];
    stb.testMode = modeQ;
  end

endmodule

// File: rtl/div_chain.sv
module div_chain
  import tap_divider_pkg::*;
#(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int TAPS    = 7
) (
  input  logic            clk,
  input  logic            clear,
  input  divStrobe_t      stb,
  output logic [TAPS-1:0] taps
);

  localparam int SECTIONS = STAGES / SECTION;

  logic [STAGES-1:0]   stageQ;
  logic [SECTIONS-1:0] sectEn;
  logic [STAGES-1:0]   lowMask;

  // Section s steps when every stage below it is one (normal mode), or on
  // every edge (test mode)
  always_comb begin
    lowMask = '0;
    for (int s = 0; s < SECTIONS; s++) begin
      lowMask   = (STAGES'(1) << (s * SECTION)) - STAGES'(1);
      sectEn[s] = stb.advance &
                  (stb.testMode || ((stageQ & lowMask) == lowMask));
    end
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
    logic [SECTION-1:0] secQ;
    always_ff @(posedge clk or posedge clear) begin
      if (clear)          secQ <= '0;
      else if (sectEn[s]) secQ <= secQ + SECTION'(1);
    end
    assign stageQ[s*SECTION +: SECTION] = secQ;
  end

  assign taps = stageQ[STAGES-1 -: TAPS];

endmodule

// File: rtl/tap_divider.sv
module tap_divider
  import tap_divider_pkg::*;
#(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int TAPS    = 7
) (
  input  logic            clk,
  input  logic            clear,
  input  logic            cntClk,
  input  logic            testSel,
  output logic [TAPS-1:0] taps
);

  divStrobe_t stb;

  div_ctrl u_ctrl (
    .clk     (clk),
    .clear   (clear),
    .cntClk  (cntClk),
    .testSel (testSel),
    .stb     (stb)
  );

  div_chain #(
    .STAGES  (STAGES),
    .SECTION (SECTION),
    .TAPS    (TAPS)
  ) u_chain (
    .clk   (clk),
    .clear (clear),
    .stb   (stb),
    .taps  (taps)
  );

endmodule

// File: rtl/tap_divider_chk.sv
module tap_divider_chk
  import tap_divider_pkg::*;
#(
  parameter int TAPS = 7
) (
  input logic            clk,
  input logic            clear,
  input logic [TAPS-1:0] taps,
  input divStrobe_t      stb
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) clear |-> taps == '0); // R1

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (clear)
    !stb.advance |=> $stable(taps)); // R2

  AST_TOP_STEP: assert property (@(posedge clk) disable iff (clear)
    !stb.testMode |=> (taps == $past(taps) || taps == $past(taps) + TAPS'(1))); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (clear)
    !clear ##1 !clear |-> $stable(stb.testMode)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (clear)
    stb.advance |=> !stb.advance); // R9

endmodule

bind tap_divider tap_divider_chk #(.TAPS(TAPS)) u_chk (
  .clk   (clk),
  .clear (clear),
  .taps  (taps),
  .stb   (stb)
);

// File: tb/tap_divider_test.sv
module tap_divider_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       clear;
  logic       cntClk;
  logic       testSel;
  logic [6:0] tapsBig;
  logic [6:0] tapsSmall;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit testOn = 1'b0;

  tap_divider uut (
    .clk(clk), .clear(clear), .cntClk(cntClk), .testSel(testSel), .taps(tapsBig)
  );

  tap_divider #(.STAGES(12), .SECTION(4), .TAPS(7)) uutSmall (
    .clk(clk), .clear(clear), .cntClk(cntClk), .testSel(testSel), .taps(tapsSmall)
  );

  function automatic logic [6:0] expTaps(int stages, int section, int cnt, bit tm);
    longint full;
    if (!tm) full = longint'(cnt) % (64'd1 << stages);
    else begin
      full = 0;
      for (int s = 0; s < stages / section; s++)
        full = full | ((longint'(cnt) % (64'd1 << section)) << (s * section));
    end
    return 7'(full >> (stages - 7));
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edges=%0d actual=%h expected=%h", req, n, act, exp);
    end
  endtask

  task automatic checkBoth(string req);
    chk(req, tapsBig,   expTaps(24, 8, n, testOn));
    chk(req, tapsSmall, expTaps(12, 4, n, testOn));
  endtask

  task automatic pulse();
    cntClk = 1'b1;
    repeat (4) @(negedge clk);
    cntClk = 1'b0;
    repeat (4) @(negedge clk);
    n++;
  endtask

  task automatic doClear(bit tm);
    testSel = tm;
    clear   = 1'b1;
    repeat (2) @(negedge clk);
    clear   = 1'b0;
    testSel = ~tm;  // R7: ignored from here on
    n       = 0;
    testOn  = tm;
    @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    testSel = 1'b0;
    cntClk  = 1'b0;
    clear   = 1'b1;
    #1;
    chk("R1", tapsBig, 7'h00);
    chk("R1", tapsSmall, 7'h00);
    repeat (2) @(negedge clk);
    clear = 1'b0;
    @(negedge clk);

    // R2: rising edge alone does not count
    repeat (31) pulse();
    checkBoth("R3");
    cntClk = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2", tapsSmall, 7'h00);
    cntClk = 1'b0;
    repeat (4) @(negedge clk);
    n++;
    chk("R2", tapsSmall, 7'h01);

    // Normal sweep through a full wrap of the small instance; testSel toggled (R7)
    while (n < 4200) begin
      if (n == 2000) testSel = 1'b1;
      if (n == 2100) testSel = 1'b0;
      pulse();
      checkBoth(n >= 4096 ? "R4" : (n > 2000 && n <= 2100) ? "R7" : "R3");
    end

    // R1: asynchronous clear between clock edges
    @(negedge clk);
    #1 clear = 1'b1;
    #1;
    chk("R1", tapsSmall, 7'h00);
    chk("R1", tapsBig, 7'h00);

    // R8: edges during clear are ignored
    for (int i = 0; i < 40; i++) pulse();
    chk("R8", tapsSmall, 7'h00);
    chk("R8", tapsBig, 7'h00);
    clear = 1'b0;
    n = 0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      pulse();
      checkBoth("R8");
    end

    // Test mode
    doClear(1'b1);
    for (int i = 0; i < 255; i++) begin
      pulse();
      checkBoth("R5");
    end
    chk("R5", tapsBig, 7'h7F);
    chk("R5", tapsSmall, 7'h7F);
    pulse();
    chk("R6", tapsBig, 7'h00);
    chk("R6", tapsSmall, 7'h00);
    for (int i = 0; i < 60; i++) begin
      pulse();
      checkBoth("R5");
    end

    // Back to normal mode
    doClear(1'b0);
    for (int i = 0; i < 100; i++) begin
      pulse();
      checkBoth("R9");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog edges=%0d actual=running expected=done", n);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule